// File: doc/BRIEF.md
# Banked Translation Entry Array with Replicated Read Port

This block stores a small table of address-translation entries, each made of a physical page number and a set of permission bits. The table is split into equal banks. A read presents one entry index. The upper bits of the index choose a bank and the lower bits choose a row inside that bank. In the request cycle, every bank is read combinationally at the same row, and every bank result is captured in its own register. The bank choice is captured next to the data. In the following cycle a multiplexer uses that registered choice to pick one bank result.

The chosen entry is driven out as several identical copies. Each consumer gets its own copy, and those consumers may sit far apart on the die. One scalar write port updates one entry per cycle. If a read and a write in the same cycle target the same entry, the read returns the data being written, not the old contents. Tag matching, entry validity and refill policy are handled by the logic around this array.

Top module: `dup_lookup_array`

## Requirements
- R1: After reset `rsp_valid` is 0 and every entry reads back as all-zero page number and permission bits.
- R2: `rsp_valid` is 1 in the cycle right after a cycle with `rd_en` high, and 0 after a cycle with `rd_en` low.
- R3: A read of index i returns the page number and permissions most recently written to index i. Index bits [IDX_W-1:OFF_W] select the bank and bits [OFF_W-1:0] select the row inside it.
- R4: When `wr_en` and `rd_en` are both high with `wr_idx == rd_idx`, the response in the next cycle carries the write data.
- R5: When a write and a read in the same cycle target different indices, the read returns the value the read entry held before that cycle, and the written entry takes the new value.
- R6: All DUP copies on `rsp_ppn` and `rsp_perm` are always identical. Copy k occupies bits [k*W +: W].
- R7: After a cycle with `rd_en` low, `rsp_ppn` and `rsp_perm` hold their previous values, even when a write happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Entry index to read |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Entry index to write |
| wr_ppn | input | PPN_W | Page number to store |
| wr_perm | input | PERM_W | Permission bits to store |
| rsp_valid | output | 1 | Response valid, one cycle after the read |
| rsp_ppn | output | DUP*PPN_W | Replicated page number copies |
| rsp_perm | output | DUP*PERM_W | Replicated permission copies |

## Verification
The bench builds the array with 16 entries in 4 banks, 8-bit page numbers, 4-bit permissions and 3 copies. At that size every index can be swept for the reset-zero state, for plain write-then-read, for a same-index bypass and for a different-index write beside each read. Because every bank appears in each sweep, a wrong bank split or a wrong registered select shows up as a mismatch on a computed value. Each response is checked copy by copy, and idle cycles that carry writes confirm that the held output does not change.

// File: rtl/lut_pkg.sv
package lut_pkg;
  // Width needed to index n items, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int DEPTH = 4,
  parameter int W     = 12,
  localparam int OFF_W = lut_pkg::idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] rd_off,
  output logic [W-1:0]     rd_q
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_comb;

  // Asynchronous read with same-cycle write forwarding.
  always_comb begin
    rd_comb = mem[rd_off];
    if (wr_en && (wr_off == rd_off)) rd_comb = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en) mem[wr_off] <= wr_data;
      if (rd_en) rd_q <= rd_comb;
    end
  end
endmodule

// File: rtl/lut_sel_dup.sv
module lut_sel_dup #(
  parameter int NBANKS = 4,
  parameter int W      = 12,
  parameter int DUP    = 3,
  localparam int SEL_W = lut_pkg::idx_width(NBANKS)
) (
  input  logic [NBANKS*W-1:0] bank_q,
  input  logic [SEL_W-1:0]    sel,
  output logic [DUP*W-1:0]    dup_out
);
  logic [W-1:0] chosen;

  always_comb begin
    chosen = '0;
    for (int b = 0; b < NBANKS; b++)
      if (sel == SEL_W'(b)) chosen = bank_q[b*W +: W];
  end

  for (genvar k = 0; k < DUP; k++) begin : g_copy
    assign dup_out[k*W +: W] = chosen;
  end
endmodule

// File: rtl/dup_lookup_array.sv
module dup_lookup_array #(
  parameter int ENTRIES = 16,
  parameter int NBANKS  = 4,
  parameter int PPN_W   = 8,
  parameter int PERM_W  = 4,
  parameter int DUP     = 3,
  localparam int IDX_W  = lut_pkg::idx_width(ENTRIES),
  localparam int BANK_W = lut_pkg::idx_width(NBANKS),
  localparam int DEPTH  = ENTRIES / NBANKS,
  localparam int OFF_W  = lut_pkg::idx_width(DEPTH),
  localparam int EW     = PPN_W + PERM_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [PPN_W-1:0]      wr_ppn,
  input  logic [PERM_W-1:0]     wr_perm,
  output logic                  rsp_valid,
  output logic [DUP*PPN_W-1:0]  rsp_ppn,
  output logic [DUP*PERM_W-1:0] rsp_perm
);
  if ((ENTRIES % NBANKS) != 0 || NBANKS < 2 || DEPTH < 2) begin : g_bad_cfg
    $error("dup_lookup_array: NBANKS must divide ENTRIES, with at least 2 banks of 2 rows");
  end

  logic [BANK_W-1:0]    rd_bank, wr_bank, sel_q;
  logic [OFF_W-1:0]     rd_off, wr_off;
  logic [EW-1:0]        wr_data;
  logic [NBANKS*EW-1:0] bank_q;
  logic [DUP*EW-1:0]    dup_out;

  assign rd_bank = rd_idx[IDX_W-1 -: BANK_W];
  assign wr_bank = wr_idx[IDX_W-1 -: BANK_W];
  assign rd_off  = rd_idx[OFF_W-1:0];
  assign wr_off  = wr_idx[OFF_W-1:0];
  assign wr_data = {wr_ppn, wr_perm};

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    lut_bank #(.DEPTH(DEPTH), .W(EW)) i_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en && (wr_bank == BANK_W'(b))),
      .wr_off  (wr_off),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_off  (rd_off),
      .rd_q    (bank_q[b*EW +: EW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) sel_q <= rd_bank;
    end
  end

  lut_sel_dup #(.NBANKS(NBANKS), .W(EW), .DUP(DUP)) i_sel (
    .bank_q  (bank_q),
    .sel     (sel_q),
    .dup_out (dup_out)
  );

  for (genvar k = 0; k < DUP; k++) begin : g_split
    assign rsp_ppn[k*PPN_W +: PPN_W]    = dup_out[k*EW + PERM_W +: PPN_W];
    assign rsp_perm[k*PERM_W +: PERM_W] = dup_out[k*EW +: PERM_W];
  end
endmodule

// File: rtl/lut_chk.sv
module lut_chk #(
  parameter int IDX_W  = 4,
  parameter int PPN_W  = 8,
  parameter int PERM_W = 4,
  parameter int DUP    = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rd_en,
  input logic [IDX_W-1:0]      rd_idx,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [PPN_W-1:0]      wr_ppn,
  input logic [PERM_W-1:0]     wr_perm,
  input logic                  rsp_valid,
  input logic [DUP*PPN_W-1:0]  rsp_ppn,
  input logic [DUP*PERM_W-1:0] rsp_perm
);
  // R2
  valid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rsp_valid);
  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rsp_valid);
  // R4
  bypass_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && rd_idx == wr_idx) |=>
      (rsp_ppn[PPN_W-1:0] == $past(wr_ppn) && rsp_perm[PERM_W-1:0] == $past(wr_perm)));
  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rsp_ppn) && $stable(rsp_perm)));

  // R6
  always_comb begin
    if (!rst) begin
      for (int k = 1; k < DUP; k++) begin
        copies_equal_chk: assert (rsp_ppn[k*PPN_W +: PPN_W] == rsp_ppn[PPN_W-1:0] &&
                                  rsp_perm[k*PERM_W +: PERM_W] == rsp_perm[PERM_W-1:0]);
      end
    end
  end
endmodule

bind dup_lookup_array lut_chk #(
  .IDX_W(IDX_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .DUP(DUP)
) i_lut_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_ppn(wr_ppn), .wr_perm(wr_perm), .rsp_valid(rsp_valid),
  .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm)
);

// File: tb/test_dup_lookup_array.sv
module test_dup_lookup_array;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 16, NBANKS = 4, PPN_W = 8, PERM_W = 4, DUP = 3;
  localparam int IDX_W = 4;

  logic clk = 0, rst = 1;
  logic rd_en = 0, wr_en = 0;
  logic [IDX_W-1:0] rd_idx = '0, wr_idx = '0;
  logic [PPN_W-1:0] wr_ppn = '0;
  logic [PERM_W-1:0] wr_perm = '0;
  logic rsp_valid;
  logic [DUP*PPN_W-1:0] rsp_ppn;
  logic [DUP*PERM_W-1:0] rsp_perm;

  int tests = 0, fails = 0;
  logic [PPN_W-1:0]  m_ppn [ENTRIES];
  logic [PERM_W-1:0] m_perm[ENTRIES];

  always #(CLK_PERIOD/2) clk = ~clk;

  dup_lookup_array #(.ENTRIES(ENTRIES), .NBANKS(NBANKS), .PPN_W(PPN_W),
                     .PERM_W(PERM_W), .DUP(DUP)) i_dup_lookup_array (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_ppn(wr_ppn), .wr_perm(wr_perm), .rsp_valid(rsp_valid),
    .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm));

  function automatic logic [PPN_W-1:0] pat_ppn(int i, int k);
    return PPN_W'(i * 13 + k * 29 + 1);
  endfunction
  function automatic logic [PERM_W-1:0] pat_perm(int i, int k);
    return PERM_W'(i ^ (k * 5 + 3));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Checks every copy of the response against the expected entry.
  task automatic check_rsp(string req, logic [PPN_W-1:0] ep, logic [PERM_W-1:0] em);
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    for (int k = 0; k < DUP; k++) begin
      check({req, " R6 ppn copy"}, 32'(rsp_ppn[k*PPN_W +: PPN_W]), 32'(ep));
      check({req, " R6 perm copy"}, 32'(rsp_perm[k*PERM_W +: PERM_W]), 32'(em));
    end
  endtask

  // Drive at negedge, let one posedge pass, return at the next negedge.
  task automatic tick(logic re, int ri, logic we, int wi, logic [PPN_W-1:0] p, logic [PERM_W-1:0] m);
    rd_en = re; rd_idx = IDX_W'(ri); wr_en = we; wr_idx = IDX_W'(wi); wr_ppn = p; wr_perm = m;
    @(posedge clk); @(negedge clk);
    if (we) begin m_ppn[wi] = p; m_perm[wi] = m; end
    rd_en = 0; wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [PPN_W-1:0] hp;
    logic [PERM_W-1:0] hm;
    for (int i = 0; i < ENTRIES; i++) begin m_ppn[i] = '0; m_perm[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 valid after reset", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < ENTRIES; i++) begin
      tick(1, i, 0, 0, '0, '0);
      check_rsp("R1 reset zero", '0, '0);
    end
    // R2: idle cycle drops valid
    tick(0, 0, 0, 0, '0, '0);
    check("R2 idle valid", 32'(rsp_valid), 32'd0);
    // R3: fill every entry, read back in reverse order
    for (int i = 0; i < ENTRIES; i++) tick(0, 0, 1, i, pat_ppn(i, 1), pat_perm(i, 1));
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      tick(1, i, 0, 0, '0, '0);
      check_rsp("R3 readback", pat_ppn(i, 1), pat_perm(i, 1));
    end
    // R4: same-index write and read in one cycle
    for (int i = 0; i < ENTRIES; i++) begin
      tick(1, i, 1, i, pat_ppn(i, 2), pat_perm(i, 2));
      check_rsp("R4 bypass", pat_ppn(i, 2), pat_perm(i, 2));
    end
    // R5: write a neighbour in the same bank row while reading
    for (int i = 0; i < ENTRIES; i++) begin
      int j;
      j = (i + 4) % ENTRIES;
      hp = m_ppn[i]; hm = m_perm[i];
      tick(1, i, 1, j, pat_ppn(j, 3), pat_perm(j, 3));
      check_rsp("R5 old value", hp, hm);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      tick(1, i, 0, 0, '0, '0);
      check_rsp("R5 written value", m_ppn[i], m_perm[i]);
    end
    // R7: output holds across idle cycles that write the shown entry
    tick(1, 5, 0, 0, '0, '0);
    hp = rsp_ppn[PPN_W-1:0]; hm = rsp_perm[PERM_W-1:0];
    for (int k = 0; k < 3; k++) begin
      tick(0, 5, 1, 5, pat_ppn(5, 7 + k), pat_perm(5, 7 + k));
      check("R7 hold ppn", 32'(rsp_ppn[PPN_W-1:0]), 32'(hp));
      check("R7 hold perm", 32'(rsp_perm[PERM_W-1:0]), 32'(hm));
      check("R7 R2 valid low", 32'(rsp_valid), 32'd0);
    end
    tick(1, 5, 0, 0, '0, '0);
    check_rsp("R3 after hold", m_ppn[5], m_perm[5]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule